// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a slower peripheral clock from its input clock. Software loads a divisor code through a small write-strobe register port and separately sets or clears a run (gate) request. The code is decoded into an effective ratio. A code of zero selects the largest ratio. In the wide build, the top code bit switches in a fixed divide-by-64 prescale. A counter then produces a registered, glitch-free output clock whose period equals the decoded ratio.

A new divisor is not applied at once. It waits for the end of the current output period, so the output never carries a shortened pulse. Two busy flags in the status word stay set from the divisor write until that period end. Gate changes are applied at the same period boundary, which always falls in the low phase, so turning the clock off never cuts a high pulse short. The status word also returns the software enable and the running gate state, and a separate output reports the divisor that is currently in effect.

Top module: `gdiv_top`

## Requirements
- R1: A nonzero code with no prescale selected divides by the code value. This covers codes 1 to 31 in both builds, and `div_code[5]`=0 in the wide build.
- R2: Code 0 divides by 2^DIV_W. That is 32 in the default 5-bit build (WIDE=0) and 64 in the 6-bit build (WIDE=1).
- R3: In the 6-bit build, a code with bit 5 set divides by 64 times the value of bits 4:0. When bits 4:0 are zero, it divides by 64.
- R4: While running, `clk_out` is periodic with a period equal to the effective divisor N. Its high phase lasts floor(N/2) input cycles and its low phase ceil(N/2). For N=1, `clk_out` stays high.
- R5: `ctrl_stat[0]` reads back the last written gate request. `ctrl_stat[1]` is the running state, and `clk_out` is low whenever it is 0. A gate change takes effect only at a period end, so a high pulse in progress completes at full length.
- R6: `ctrl_stat[3]` and `ctrl_stat[4]` are both set in the cycle after a divisor write. They stay set until the period end at which the new divisor is applied. `eff_div` keeps the old value while they are set.
- R7: While stopped, a divisor write has no effect on `clk_out`, which stays low. The write is applied, and the busy flags clear, one cycle after it is taken.
- R8: After reset, `ctrl_stat` is 0, `clk_out` is low and `eff_div` equals 2^DIV_W.
- R9: `eff_div` reports the decoded divisor currently in effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| div_we | input | 1 | Write strobe for the divisor code |
| div_code | input | DIV_W | Divisor code (5 bits, or 6 when WIDE=1) |
| gate_we | input | 1 | Write strobe for the gate request |
| gate_val | input | 1 | Gate request value (1 = run) |
| clk_out | output | 1 | Divided, gated output clock (registered) |
| ctrl_stat | output | 8 | Bit 0 gate request, bit 1 running, bits 3 and 4 busy, others 0 |
| eff_div | output | 12 | Effective divisor in use |

## Verification
The output period and high time are measured for codes 0, 1, 2, 31, 0x20, 0x21 and 0x3F in the 6-bit build, with codes 0 and 31 repeated in the 5-bit build. Together these codes separate the zero-code maximum, the plain ratio, the odd-ratio duty split, the prescaled ratio and the prescale with zero low bits. A divisor write issued early in a long period shows that busy holds and the applied ratio stays unchanged until the boundary. A gate-off request issued just after a rising edge shows that the high pulse completes and no further edge follows. A write while stopped shows that the output is unaffected and the update is immediate.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;

    localparam int EFF_W = 12;

    typedef logic [EFF_W-1:0] eff_t;

    typedef struct packed {
        eff_t cnt;
        eff_t div;
        logic act;
        logic out;
    } phase_t;

    function automatic eff_t dec_narrow(input logic [4:0] code);
        return (code == 5'd0) ? eff_t'(32) : eff_t'(code);
    endfunction

    function automatic eff_t dec_wide(input logic [5:0] code);
        if (code[4:0] == 5'd0)
            return eff_t'(64);
        if (code[5])
            return eff_t'({code[4:0], 6'b0});
        return eff_t'(code[4:0]);
    endfunction

    function automatic eff_t hi_len(input eff_t n);
        return (n == eff_t'(1)) ? eff_t'(1) : (n >> 1);
    endfunction

endpackage

// File: rtl/gdiv_decode.sv
module gdiv_decode
    import gdiv_pkg::*;
#(
    parameter bit WIDE  = 1'b0,
    parameter int DIV_W = WIDE ? 6 : 5
) (
    input  logic [DIV_W-1:0] code,
    output eff_t             div
);
    generate
        if (WIDE) begin : g_wide
            assign div = dec_wide(code);
        end else begin : g_narrow
            assign div = dec_narrow(code);
        end
    endgenerate
endmodule

// File: rtl/gdiv_regs.sv
module gdiv_regs #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_code,
    input  logic             gate_we,
    input  logic             gate_val,
    input  logic             boundary,
    output logic [DIV_W-1:0] pend_code,
    output logic             gate_req,
    output logic             busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_code <= '0;
            gate_req  <= 1'b0;
            busy      <= 1'b0;
        end else begin
            if (gate_we)
                gate_req <= gate_val;
            if (div_we) begin
                pend_code <= div_code;
                busy      <= 1'b1;
            end else if (boundary) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/gdiv_phase.sv
module gdiv_phase
    import gdiv_pkg::*;
#(
    parameter int RST_DIV = 32
) (
    input  logic clk,
    input  logic rst,
    input  eff_t new_div,
    input  logic gate_req,
    output logic boundary,
    output logic running,
    output logic clk_out,
    output eff_t cur_div
);
    phase_t st;
    phase_t nxt;

    always_comb begin
        boundary = (st.cnt == st.div - eff_t'(1));
        nxt      = st;
        if (boundary) begin
            nxt.div = new_div;
            nxt.act = gate_req;
            nxt.cnt = gate_req ? '0 : new_div - eff_t'(1);
        end else begin
            nxt.cnt = st.cnt + eff_t'(1);
        end
        nxt.out = nxt.act && (nxt.cnt < hi_len(nxt.div));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.cnt <= eff_t'(RST_DIV - 1);
            st.div <= eff_t'(RST_DIV);
            st.act <= 1'b0;
            st.out <= 1'b0;
        end else begin
            st <= nxt;
        end
    end

    assign running = st.act;
    assign clk_out = st.out;
    assign cur_div = st.div;
endmodule

// File: rtl/gdiv_top.sv
module gdiv_top
    import gdiv_pkg::*;
#(
    parameter bit WIDE = 1'b0,
    localparam int DIV_W   = WIDE ? 6 : 5,
    localparam int RST_DIV = 1 << DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_code,
    input  logic             gate_we,
    input  logic             gate_val,
    output logic             clk_out,
    output logic [7:0]       ctrl_stat,
    output logic [EFF_W-1:0] eff_div
);
    logic [DIV_W-1:0] pend_code;
    logic             gate_req;
    logic             busy;
    logic             boundary;
    logic             running;
    eff_t             new_div;
    eff_t             cur_div;

    gdiv_regs #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .div_we    (div_we),
        .div_code  (div_code),
        .gate_we   (gate_we),
        .gate_val  (gate_val),
        .boundary  (boundary),
        .pend_code (pend_code),
        .gate_req  (gate_req),
        .busy      (busy)
    );

    gdiv_decode #(.WIDE(WIDE), .DIV_W(DIV_W)) u_dec (
        .code (pend_code),
        .div  (new_div)
    );

    gdiv_phase #(.RST_DIV(RST_DIV)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .new_div  (new_div),
        .gate_req (gate_req),
        .boundary (boundary),
        .running  (running),
        .clk_out  (clk_out),
        .cur_div  (cur_div)
    );

    assign ctrl_stat = {3'b000, busy, busy, 1'b0, running, gate_req};
    assign eff_div   = cur_div;
endmodule

// File: rtl/gdiv_chk.sv
module gdiv_chk (
    input logic        clk,
    input logic        rst,
    input logic        div_we,
    input logic        clk_out,
    input logic        run,
    input logic        busy_a,
    input logic        busy_b,
    input logic [11:0] eff_div
);
    // R6: both busy flags rise together after a divisor write
    a_r6_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        div_we |=> (busy_a && busy_b));

    // R6: the two busy flags always agree
    a_r6_busy_pair: assert property (@(posedge clk) disable iff (rst)
        busy_a == busy_b);

    // R6: applied divisor changes only at the end of a busy window
    a_r6_eff_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_a && !$past(busy_a) && !$past(div_we)) |-> $stable(eff_div));

    // R5: output is low while stopped
    a_r5_stopped_low: assert property (@(posedge clk) disable iff (rst)
        !run |-> !clk_out);

    // R5: the running state flips only after a low output cycle
    a_r5_gate_at_low: assert property (@(posedge clk) disable iff (rst)
        ((run != $past(run)) && ($past(eff_div) != 12'd1)) |-> !$past(clk_out));

    // R9: effective divisor is never zero
    a_r9_div_nonzero: assert property (@(posedge clk) disable iff (rst)
        eff_div != 12'd0);
endmodule

bind gdiv_top gdiv_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .div_we  (div_we),
    .clk_out (clk_out),
    .run     (ctrl_stat[1]),
    .busy_a  (ctrl_stat[3]),
    .busy_b  (ctrl_stat[4]),
    .eff_div (eff_div)
);

// File: tb/gdiv_top_test.sv
module gdiv_top_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        div_we = 1'b0;
    logic [5:0]  div_code = '0;
    logic        gate_we = 1'b0;
    logic        gate_val = 1'b0;

    logic        w_out, n_out;
    logic [7:0]  w_stat, n_stat;
    logic [11:0] w_eff, n_eff;

    int total = 0;
    int bad = 0;

    gdiv_top #(.WIDE(1'b1)) uut (
        .clk(clk), .rst(rst), .div_we(div_we), .div_code(div_code),
        .gate_we(gate_we), .gate_val(gate_val),
        .clk_out(w_out), .ctrl_stat(w_stat), .eff_div(w_eff)
    );

    gdiv_top #(.WIDE(1'b0)) uut_n (
        .clk(clk), .rst(rst), .div_we(div_we), .div_code(div_code[4:0]),
        .gate_we(gate_we), .gate_val(gate_val),
        .clk_out(n_out), .ctrl_stat(n_stat), .eff_div(n_eff)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit outv(input bit sel);
        return sel ? n_out : w_out;
    endfunction

    task automatic wr_div(input logic [5:0] c);
        @(negedge clk);
        div_we = 1'b1;
        div_code = c;
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic wr_gate(input logic v);
        @(negedge clk);
        gate_we = 1'b1;
        gate_val = v;
        @(negedge clk);
        gate_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!w_stat[3] && !n_stat[3]) break;
            @(negedge clk);
        end
    endtask

    task automatic measure(input bit sel, output int per, output int hi);
        bit prev, c;
        int guard;
        guard = 0;
        prev = outv(sel);
        per = -1;
        hi = -1;
        forever begin
            @(negedge clk);
            c = outv(sel);
            if (!prev && c) break;
            prev = c;
            guard++;
            if (guard > 5000) return;
        end
        per = 1;
        hi = 1;
        prev = 1'b1;
        guard = 0;
        forever begin
            @(negedge clk);
            c = outv(sel);
            if (!prev && c) break;
            per++;
            if (c) hi++;
            prev = c;
            guard++;
            if (guard > 5000) begin
                per = -1;
                return;
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 wide status", int'(w_stat), 0);
        chk("R8 wide clk_out", int'(w_out), 0);
        chk("R8 wide eff_div", int'(w_eff), 64);
        chk("R8 narrow eff_div", int'(n_eff), 32);
    endtask

    task automatic t_enable();
        wr_gate(1'b1);
        chk("R5 gate readback", int'(w_stat[0]), 1);
        @(negedge clk);
        chk("R5 running after enable", int'(w_stat[1]), 1);
    endtask

    task automatic t_code(input logic [5:0] c, input string tag, input int exp_w,
                          input int exp_n, input bit meas_n);
        int per, hi;
        wr_div(c);
        wait_idle();
        chk({tag, " wide eff_div"}, int'(w_eff), exp_w);
        chk({tag, " narrow eff_div"}, int'(n_eff), exp_n);
        measure(1'b0, per, hi);
        chk({tag, " R4 wide period"}, per, exp_w);
        chk({tag, " R4 wide high"}, hi, exp_w / 2);
        if (meas_n) begin
            measure(1'b1, per, hi);
            chk({tag, " R4 narrow period"}, per, exp_n);
            chk({tag, " R4 narrow high"}, hi, exp_n / 2);
        end
    endtask

    task automatic t_code1();
        int highs;
        wr_div(6'd1);
        wait_idle();
        chk("R1 code 1 eff_div", int'(w_eff), 1);
        @(negedge clk);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (w_out) highs++;
        end
        chk("R4 divide by one stays high", highs, 20);
    endtask

    task automatic t_busy();
        int per, hi;
        wr_div(6'd0);
        wait_idle();
        measure(1'b0, per, hi);
        wr_div(6'd2);
        chk("R6 busy bit3 after write", int'(w_stat[3]), 1);
        chk("R6 busy bit4 after write", int'(w_stat[4]), 1);
        repeat (10) @(negedge clk);
        chk("R6 busy held mid period", int'(w_stat[3]), 1);
        chk("R6 old divisor held", int'(w_eff), 64);
        wait_idle();
        chk("R6 new divisor applied", int'(w_eff), 2);
        measure(1'b0, per, hi);
        chk("R4 code 2 period", per, 2);
    endtask

    task automatic t_trunc();
        int per, hi, highs, rises;
        bit prev, c;
        wr_div(6'd31);
        wait_idle();
        measure(1'b0, per, hi);
        chk("R4 odd divisor low phase", per - hi, 16);
        measure(1'b0, per, hi);
        gate_we = 1'b1;
        gate_val = 1'b0;
        highs = 1;
        rises = 0;
        prev = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (i == 0) gate_we = 1'b0;
            c = w_out;
            if (c) highs++;
            if (!prev && c) rises++;
            prev = c;
        end
        chk("R5 high pulse completes after gate off", highs, 15);
        chk("R5 no edge after gate off", rises, 0);
        chk("R5 gate readback off", int'(w_stat[0]), 0);
        chk("R5 running cleared", int'(w_stat[1]), 0);
    endtask

    task automatic t_stopped();
        int highs;
        wr_div(6'd2);
        chk("R7 busy taken while stopped", int'(w_stat[3]), 1);
        @(negedge clk);
        chk("R7 busy clears at once", int'(w_stat[3]), 0);
        chk("R7 divisor applied at once", int'(w_eff), 2);
        highs = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (w_out) highs++;
        end
        chk("R7 output stays low while stopped", highs, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_enable();
        t_code(6'd0,  "R2 code 0",    64,   32, 1'b1);
        t_code(6'd2,  "R1 code 2",    2,    2,  1'b0);
        t_code(6'd31, "R1 code 31",   31,   31, 1'b1);
        t_code(6'h21, "R3 code 0x21", 64,   1,  1'b0);
        t_code(6'h3F, "R3 code 0x3F", 1984, 31, 1'b0);
        t_code(6'h20, "R3 code 0x20", 64,   32, 1'b0);
        t_code1();
        t_busy();
        t_trunc();
        t_stopped();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule